// File: doc/BRIEF.md
# Dual-Output PWM Generator Core

This block generates two raw pulse-width modulated waveforms, A and B, from one shared 16-bit counter. The counter runs either as a reloading down-counter, for left- or right-aligned pulses, or as an up/down counter, for centre-aligned pulses. Two compare values, one per output, are checked against the count. Each match is split by count direction into an up event and a down event. Each output then applies a 2-bit action code to every event that concerns it: the counter reaching zero, the counter reaching the load value, and its own compare matching while counting up or while counting down.

Load and compare values are held in working copies. These copies are refreshed from the inputs at a zero of the counter. In immediate mode every zero refreshes them. In synchronous mode only the first zero after a global update strobe does, so several generators can change period and duty in the same cycle. A global counter clear keeps several generators phase-aligned. An interrupt pulse and a converter-trigger pulse are each raised whenever any event in their own selection mask occurs.

Top module: `pwmg_core`

## Requirements
- R1: In count-down mode (`updown_i`=0) the count steps load, load-1, ... 0, then reloads. Once enabled from zero, the count seen after the k-th enabled edge is L-((k-1) mod (L+1)).
- R2: In up/down mode the count goes 0, 1, ... L, L-1, ... 0 and repeats, with period 2L. With L=0 it stays at 0.
- R3: A compare value c produces a match event only in a cycle where the count equals c and c is not above the working load value. In up/down mode the match is an up event while the count is rising and a down event while it is falling. In count-down mode every match is a down event.
- R4: A match event in the same cycle as a zero or load event is dropped. Output A reacts only to compare A matches, and output B only to compare B matches.
- R5: Each output has an 8-bit action field. Bits [1:0] apply at zero, [3:2] at load, [5:4] at an own match going up, and [7:6] at an own match going down. Code 00 holds, 01 toggles, 10 drives low, 11 drives high. When several events coincide, load wins over zero, and zero wins over a match. The output takes its new value at the clock edge that ends the event cycle.
- R6: The event vector is bit 0 zero, bit 1 load, bit 2 A-up, bit 3 A-down, bit 4 B-up, bit 5 B-down. `irq_o` and `trig_o` are high for one cycle after any cycle in which a bit set in `irq_sel_i` or `trig_sel_i` respectively has an event.
- R7: With `upd_sync_i`=0, new load and compare inputs take effect at the next zero. The reload that follows that zero already uses the new load value.
- R8: With `upd_sync_i`=1, new values are ignored at zeros until `gupd_i` has been high on some earlier edge. They are then taken at the first zero after that.
- R9: `grst_i` high at an edge clears the count to 0, and counting resumes from there.
- R10: With `en_i` low the count is held at 0, both outputs are low, no pulses are raised, and the working values follow the inputs.
- R11: While `rst_ni` is low the count, both outputs and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Generator enable |
| updown_i | input | 1 | 1: up/down counting, 0: count-down |
| upd_sync_i | input | 1 | 1: values update only after the global strobe |
| grst_i | input | 1 | Global synchronous counter clear |
| gupd_i | input | 1 | Global update strobe |
| load_i | input | 16 | Load (period) value |
| cmpa_i | input | 16 | Compare value for output A |
| cmpb_i | input | 16 | Compare value for output B |
| act_a_i | input | 8 | Action field for output A |
| act_b_i | input | 8 | Action field for output B |
| irq_sel_i | input | 6 | Event mask for the interrupt pulse |
| trig_sel_i | input | 6 | Event mask for the converter trigger |
| pwm_a_o | output | 1 | Raw PWM output A |
| pwm_b_o | output | 1 | Raw PWM output B |
| irq_o | output | 1 | Interrupt pulse |
| trig_o | output | 1 | Converter trigger pulse |
| count_o | output | 16 | Current counter value |

## Verification
Events are decoded from the count that is held during a cycle. Both PWM outputs and both pulses are registered, so they reflect the events of the count sampled one edge earlier. The count itself moves on at the same edge. The bench samples on the falling clock edge. At sample j it compares `count_o` with the arithmetic count for step j, and compares the outputs and pulses with values derived from the events of step j-1. For the directed update and clear tests, the number of edges from the input change to the zero that takes it is counted out per case, and the count is checked at exactly that step.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  localparam int EV_N    = 6;
  localparam int EV_ZERO = 0;
  localparam int EV_LOAD = 1;
  localparam int EV_AUP  = 2;
  localparam int EV_ADN  = 3;
  localparam int EV_BUP  = 4;
  localparam int EV_BDN  = 5;
  localparam int ACT_W   = 8;

  function automatic logic apply_act(act_e a, logic q);
    case (a)
      ACT_TOGGLE: return ~q;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return q;
    endcase
  endfunction
endpackage

// File: rtl/pwmg_rst_sync.sv
module pwmg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sr_q[STAGES-1];
endmodule

// File: rtl/pwmg_shadow.sv
module pwmg_shadow #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sync_mode_i,
  input  logic         gupd_i,
  input  logic         at_zero_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] cmpa_i,
  input  logic [W-1:0] cmpb_i,
  output logic [W-1:0] load_q_o,
  output logic [W-1:0] load_nx_o,
  output logic [W-1:0] cmpa_q_o,
  output logic [W-1:0] cmpb_q_o
);
  logic         armed_q, armed_d;
  logic         take;
  logic [W-1:0] load_q, cmpa_q, cmpb_q;

  always_comb begin
    take    = !en_i || (at_zero_i && (!sync_mode_i || armed_q));
    armed_d = en_i && (gupd_i || (armed_q && !take));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else if (take) begin
      load_q <= load_i;
      cmpa_q <= cmpa_i;
      cmpb_q <= cmpb_i;
    end
  end

  assign load_q_o  = load_q;
  assign load_nx_o = take ? load_i : load_q;
  assign cmpa_q_o  = cmpa_q;
  assign cmpb_q_o  = cmpb_q;
endmodule

// File: rtl/pwmg_counter.sv
module pwmg_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         updown_i,
  input  logic         grst_i,
  input  logic [W-1:0] load_q_i,
  input  logic [W-1:0] load_nx_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_up_o,
  output logic         at_zero_o,
  output logic         at_load_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (!en_i || grst_i) begin
      cnt_d = '0;
      dir_d = 1'b0;
    end else if (!updown_i) begin
      dir_d = 1'b0;
      cnt_d = (cnt_q == '0) ? load_nx_i : cnt_q - ONE;
    end else if (cnt_q == '0) begin
      dir_d = 1'b1;
      cnt_d = (load_nx_i == '0) ? '0 : ONE;
    end else if (cnt_q >= load_q_i) begin
      dir_d = 1'b0;
      cnt_d = cnt_q - ONE;
    end else begin
      cnt_d = dir_q ? cnt_q + ONE : cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign dir_up_o  = dir_q;
  assign at_zero_o = en_i && (cnt_q == '0);
  assign at_load_o = en_i && (cnt_q == load_q_i);
endmodule

// File: rtl/pwmg_action.sv
module pwmg_action
  import pwmg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACT_W-1:0] codes_i,
  input  logic             ev_zero_i,
  input  logic             ev_load_i,
  input  logic             ev_up_i,
  input  logic             ev_dn_i,
  output logic             pwm_o
);
  act_e sel;
  logic q, d;

  always_comb begin
    if (ev_load_i)      sel = act_e'(codes_i[3:2]);
    else if (ev_zero_i) sel = act_e'(codes_i[1:0]);
    else if (ev_up_i)   sel = act_e'(codes_i[5:4]);
    else if (ev_dn_i)   sel = act_e'(codes_i[7:6]);
    else                sel = ACT_HOLD;
    d = en_i ? apply_act(sel, q) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= d;
  end

  assign pwm_o = q;
endmodule

// File: rtl/pwmg_core.sv
module pwmg_core
  import pwmg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             updown_i,
  input  logic             upd_sync_i,
  input  logic             grst_i,
  input  logic             gupd_i,
  input  logic [W-1:0]     load_i,
  input  logic [W-1:0]     cmpa_i,
  input  logic [W-1:0]     cmpb_i,
  input  logic [ACT_W-1:0] act_a_i,
  input  logic [ACT_W-1:0] act_b_i,
  input  logic [EV_N-1:0]  irq_sel_i,
  input  logic [EV_N-1:0]  trig_sel_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             irq_o,
  output logic             trig_o,
  output logic [W-1:0]     count_o
);
  localparam int NOUT = 2;

  logic                       rst_n;
  logic [W-1:0]               load_q, load_nx, cnt;
  logic                       dir_up, at_zero, at_load;
  logic [NOUT-1:0][W-1:0]     cmp_q;
  logic [NOUT-1:0][ACT_W-1:0] act_cfg;
  logic [NOUT-1:0]            m_up, m_dn, pwm;
  logic [EV_N-1:0]            ev;
  logic                       irq_q, irq_d, trig_q, trig_d;

  pwmg_rst_sync #(.STAGES(2)) i_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  pwmg_shadow #(.W(W)) i_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (en_i),
    .sync_mode_i(upd_sync_i),
    .gupd_i     (gupd_i),
    .at_zero_i  (at_zero),
    .load_i     (load_i),
    .cmpa_i     (cmpa_i),
    .cmpb_i     (cmpb_i),
    .load_q_o   (load_q),
    .load_nx_o  (load_nx),
    .cmpa_q_o   (cmp_q[0]),
    .cmpb_q_o   (cmp_q[1])
  );

  pwmg_counter #(.W(W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (en_i),
    .updown_i (updown_i),
    .grst_i   (grst_i),
    .load_q_i (load_q),
    .load_nx_i(load_nx),
    .cnt_o    (cnt),
    .dir_up_o (dir_up),
    .at_zero_o(at_zero),
    .at_load_o(at_load)
  );

  assign act_cfg[0] = act_a_i;
  assign act_cfg[1] = act_b_i;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    logic hit;
    always_comb begin
      hit     = en_i && (cnt == cmp_q[g]) && (cmp_q[g] <= load_q)
                && !at_zero && !at_load;
      m_up[g] = hit && dir_up;
      m_dn[g] = hit && !dir_up;
    end

    pwmg_action i_act (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .en_i     (en_i),
      .codes_i  (act_cfg[g]),
      .ev_zero_i(at_zero),
      .ev_load_i(at_load),
      .ev_up_i  (m_up[g]),
      .ev_dn_i  (m_dn[g]),
      .pwm_o    (pwm[g])
    );
  end

  always_comb begin
    ev          = '0;
    ev[EV_ZERO] = at_zero;
    ev[EV_LOAD] = at_load;
    ev[EV_AUP]  = m_up[0];
    ev[EV_ADN]  = m_dn[0];
    ev[EV_BUP]  = m_up[1];
    ev[EV_BDN]  = m_dn[1];
    irq_d       = |(ev & irq_sel_i);
    trig_d      = |(ev & trig_sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      trig_q <= trig_d;
    end
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];
  assign irq_o   = irq_q;
  assign trig_o  = trig_q;
  assign count_o = cnt;
endmodule

// File: rtl/pwmg_core_chk.sv
module pwmg_core_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         updown_i,
  input logic         grst_i,
  input logic         pwm_a_o,
  input logic         pwm_b_o,
  input logic         irq_o,
  input logic         trig_o,
  input logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = W'(1);

  // R1
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && !updown_i && !grst_i && (count_o != '0))
      |-> count_o == $past(count_o) - ONE);

  // R2
  updown_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && updown_i && !grst_i)
      |-> (count_o == $past(count_o) + ONE) || (count_o == $past(count_o) - ONE)
          || (count_o == '0));

  // R9
  global_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(grst_i) |-> count_o == '0);

  // R10
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> (count_o == '0) && !pwm_a_o && !pwm_b_o && !irq_o && !trig_o);

  // R6
  pulse_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || trig_o) |-> $past(en_i));
endmodule

bind pwmg_core pwmg_core_chk #(.W(W)) i_pwmg_core_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .updown_i(updown_i),
  .grst_i (grst_i),
  .pwm_a_o(pwm_a_o),
  .pwm_b_o(pwm_b_o),
  .irq_o  (irq_o),
  .trig_o (trig_o),
  .count_o(count_o)
);

// File: tb/test_pwmg_core.sv
module test_pwmg_core;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        en_i, updown_i, upd_sync_i, grst_i, gupd_i;
  logic [15:0] load_i, cmpa_i, cmpb_i;
  logic [7:0]  act_a_i, act_b_i;
  logic [5:0]  irq_sel_i, trig_sel_i;
  logic        pwm_a_o, pwm_b_o, irq_o, trig_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  pwmg_core i_pwmg_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .updown_i(updown_i),
    .upd_sync_i(upd_sync_i), .grst_i(grst_i), .gupd_i(gupd_i),
    .load_i(load_i), .cmpa_i(cmpa_i), .cmpb_i(cmpb_i),
    .act_a_i(act_a_i), .act_b_i(act_b_i),
    .irq_sel_i(irq_sel_i), .trig_sel_i(trig_sel_i),
    .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .irq_o(irq_o), .trig_o(trig_o),
    .count_o(count_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_f(int k, int l, bit ud);
    int m;
    if (k == 0 || l == 0) return 0;
    if (!ud) return l - ((k - 1) % (l + 1));
    m = k % (2 * l);
    return (m <= l) ? m : 2 * l - m;
  endfunction

  function automatic bit dir_f(int k, int l, bit ud);
    int m;
    if (!ud || k == 0 || l == 0) return 1'b0;
    m = k % (2 * l);
    return (m >= 1) && (m <= l);
  endfunction

  function automatic bit act_f(logic [1:0] code, bit q);
    case (code)
      2'b01:   return ~q;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return q;
    endcase
  endfunction

  function automatic bit out_f(logic [7:0] codes, bit z, bit ld, bit up, bit dn, bit q);
    if (ld)      return act_f(codes[3:2], q);
    else if (z)  return act_f(codes[1:0], q);
    else if (up) return act_f(codes[5:4], q);
    else if (dn) return act_f(codes[7:6], q);
    return q;
  endfunction

  task automatic setup(input bit ud, input bit sy, input int l, input int ca, input int cb);
    @(negedge clk_i);
    en_i = 1'b0; updown_i = ud; upd_sync_i = sy; grst_i = 1'b0; gupd_i = 1'b0;
    load_i = 16'(l); cmpa_i = 16'(ca); cmpb_i = 16'(cb);
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic run_cfg(input bit ud, input int l, input int ca, input int cb,
                         input logic [7:0] aa, input logic [7:0] ab,
                         input logic [5:0] is, input logic [5:0] ts);
    bit ea = 1'b0, eb = 1'b0;
    int span;
    act_a_i = aa; act_b_i = ab; irq_sel_i = is; trig_sel_i = ts;
    setup(ud, 1'b0, l, ca, cb);
    span = (ud ? 2 * l : l + 1) * 3 + 2;
    for (int j = 1; j <= span; j++) begin
      int c; bit d, z, ld, ma, mb;
      logic [5:0] ev;
      @(negedge clk_i);
      c  = cnt_f(j - 1, l, ud);
      d  = dir_f(j - 1, l, ud);
      z  = (c == 0);
      ld = (c == l);
      // R3 R4: own compare only, dropped on zero/load, split by direction
      ma = (c == ca) && (ca <= l) && !z && !ld;
      mb = (c == cb) && (cb <= l) && !z && !ld;
      ev = {mb && !d, mb && d, ma && !d, ma && d, ld, z};
      ea = out_f(aa, z, ld, ma && d, ma && !d, ea);
      eb = out_f(ab, z, ld, mb && d, mb && !d, eb);
      check(ud ? "R2 count" : "R1 count", int'(count_o), cnt_f(j, l, ud));
      check("R5 pwm_a", int'(pwm_a_o), int'(ea));
      check("R5 pwm_b", int'(pwm_b_o), int'(eb));
      check("R6 irq/trig", int'({irq_o, trig_o}),
            int'({|(ev & is), |(ev & ts)}));
    end
  endtask

  initial begin
    rst_ni = 1'b0; en_i = 1'b0; updown_i = 1'b0; upd_sync_i = 1'b0;
    grst_i = 1'b0; gupd_i = 1'b0; load_i = 16'd3; cmpa_i = 16'd1; cmpb_i = 16'd2;
    act_a_i = 8'hFF; act_b_i = 8'hFF; irq_sel_i = 6'h3F; trig_sel_i = 6'h3F;
    repeat (3) @(negedge clk_i);
    // R11
    check("R11 reset count", int'(count_o), 0);
    check("R11 reset outputs", int'({pwm_a_o, pwm_b_o, irq_o, trig_o}), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 R2 R3 R4 R5 R6 sweep
    for (int ud = 0; ud < 2; ud++)
      for (int li = 0; li < 4; li++) begin
        int l = (li == 3) ? 4 : li;
        for (int ca = 0; ca <= l + 1; ca++)
          for (int cb = 0; cb <= l + 1; cb++) begin
            run_cfg(bit'(ud), l, ca, cb, 8'b10_11_00_11, 8'b11_10_01_00,
                    6'b000001, 6'b101010);
            run_cfg(bit'(ud), l, ca, cb, 8'b01_01_01_01, 8'b01_01_11_10,
                    6'b010100, 6'b000011);
          end
      end

    // R7 immediate update
    setup(1'b0, 1'b0, 3, 9, 9);
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk_i);
      if (j == 3) check("R7 old period", int'(count_o), 1);
      if (j == 5) check("R7 new load at zero", int'(count_o), 6);
      if (j == 6) check("R7 new period", int'(count_o), 5);
      if (j == 2) load_i = 16'd6;
    end

    // R8 synchronous update
    setup(1'b0, 1'b1, 3, 9, 9);
    for (int j = 1; j <= 9; j++) begin
      @(negedge clk_i);
      if (j == 5) check("R8 held without strobe", int'(count_o), 3);
      if (j == 8) check("R8 zero", int'(count_o), 0);
      if (j == 9) check("R8 new load after strobe", int'(count_o), 6);
      if (j == 2) load_i = 16'd6;
      gupd_i = (j == 5);
    end

    // R9 global clear, then R10 disable
    setup(1'b0, 1'b0, 5, 9, 9);
    act_a_i = 8'hFF; act_b_i = 8'hFF; irq_sel_i = 6'h3F; trig_sel_i = 6'h3F;
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk_i);
      if (j == 3) check("R9 before clear", int'(count_o), 3);
      if (j == 4) check("R9 cleared", int'(count_o), 0);
      if (j == 5) check("R9 resumes", int'(count_o), 5);
      grst_i = (j == 3);
    end
    en_i = 1'b0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk_i);
      check("R10 count held", int'(count_o), 0);
      check("R10 outputs low", int'({pwm_a_o, pwm_b_o, irq_o, trig_o}), 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule